// File: doc/BRIEF.md
# Synchronous Buck Switching Sequencer

This block is the digital gate-sequencing engine for one synchronous step-down channel. A one-cycle `tick` marks the rising edge of the switching period. At each such edge the block either starts a high-side pulse or idles the channel for the whole period. It ends each pulse on comparator flags, then drives the low-side switch to freewheel until inductor current reaches zero or the next period begins. A programmable dead time of fast system clocks separates every hand-over between the two gate commands. A minimum and a maximum on-time bound every pulse.

Two high-side termination rules exist. In the fixed-frequency mode, the on-time trip flag from the regulation loop ends the pulse. In the pulse-skipping mode, the light-load peak flag ends it. The mode follows from history: after a period in which no high-side pulse was issued, the channel runs in skipping mode. A period is skipped when the output-above-regulation flag is high at the period edge. A peak current-limit flag removes the high-side command in the same cycle. An enable input and a fault-clamp input force safe gate states.

The control is one state machine with these states. OFF means disabled. IDLE means both gates off while waiting. DT_HI and DT_LO are the dead-time states before the high-side and low-side gates turn on. HIGH means the high-side gate is on. LOW means the low-side gate is freewheeling. CLAMP means the fault discharge state.

Its transitions are:
- OFF to IDLE on enable.
- IDLE to DT_HI on a tick while not above regulation.
- IDLE to IDLE on a tick while above regulation (a skipped period).
- DT_HI to HIGH when the dead time expires.
- HIGH to DT_LO on termination: trip, light-load peak, current limit, maximum on-time or clamp.
- DT_LO to LOW, or to CLAMP, when the dead time expires.
- LOW to IDLE on zero crossing.
- LOW or DT_LO to DT_HI or IDLE on a tick.
- Any state except HIGH and DT_LO to CLAMP on clamp.
- CLAMP to IDLE on release.
- Any state to OFF on disable.

Top module: `buck_switch_seq`

## Requirements
- R1: Let D be the programmed dead time, with 0 treated as 1. The high-side gate rises exactly D clocks after the edge that samples `tick`. The low-side gate rises exactly D clocks after the high-side gate falls. The two gates are never high together, and neither rises in the cycle right after the other was high.
- R2: In fixed-frequency mode (`skip_mode`=0), once the minimum on-time is met, the high-side gate falls at the edge after `trip_on` is sampled high. `trip_light` has no effect on the pulse in this mode.
- R3: Neither `trip_on` nor `trip_light` ends a pulse before it has been high for MIN_ON = floor(PERIOD_CLKS*MIN_DUTY_PCT/100) clocks.
- R4: The high-side gate is low no later than MAX_ON = floor(PERIOD_CLKS*MAX_DUTY_PCT/100) clocks after the edge that sampled `tick`, whatever the flags are.
- R5: While `trip_ilim` is high, `gate_hi` is low in that same cycle. The pulse then moves to the low-side dead time. The next period's pulse is issued normally.
- R6: The low-side gate falls at the edge after `zero_cross` is sampled high. Otherwise it falls at the edge that samples the next `tick`.
- R7: A tick sampled with `out_above` high issues no pulse, and both gates stay off for that whole period.
- R8: At each taken tick, `skip_mode` becomes 1 if the ending period issued no high-side pulse, and 0 otherwise. In skipping mode the pulse ends on `trip_light`, and `trip_on` has no effect.
- R9: With `en` low, both gates are off and `skip_mode` is 0 from the next edge. This holds even when `clamp` is high.
- R10: With `en` high and `clamp` high, the high-side gate is off from the next edge. If the high-side gate was on, the low-side gate turns on after dead time D; otherwise it turns on at the next edge. Ticks are ignored during the clamp. Releasing `clamp` returns to IDLE with both gates off.
- R11: Under reset, both gates are off and `skip_mode` is 0. The first period after reset or re-enable runs in fixed-frequency mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable |
| clamp | input | 1 | Fault discharge request: low side on, high side off |
| tick | input | 1 | One-cycle pulse at each switching-period rising edge |
| bbm | input | BBM_W | Dead time in system clocks (0 acts as 1) |
| trip_on | input | 1 | Regulation-loop on-time trip flag |
| trip_ilim | input | 1 | Peak current-limit flag |
| trip_light | input | 1 | Light-load peak threshold flag |
| zero_cross | input | 1 | Inductor current has reached zero |
| out_above | input | 1 | Output is above regulation |
| gate_hi | output | 1 | High-side gate command |
| gate_lo | output | 1 | Low-side gate command |
| skip_mode | output | 1 | 1 = pulse-skipping mode, 0 = fixed-frequency mode |

## Verification
The hardest situations to reach from the ports are the mode-dependent termination and the skip history. They show only when a skipped period is followed by a pulsed one whose trip and light-load flags arrive at different offsets. The stimulus table therefore chains periods in a fixed order: a period above regulation, then a period with an early `trip_on` and a late `trip_light`. It then reverses the roles once the mode has returned. Every flag is driven at a chosen clock offset from the tick, so each gate edge has one exact expected offset. Clamp during a live pulse, current limit in mid-pulse, and disable under clamp are reached by directed sequences that time the input against an observed high-side gate.

// File: rtl/bss_pkg.sv
package bss_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_DT_HI,
        ST_HIGH,
        ST_DT_LO,
        ST_LOW,
        ST_CLAMP
    } bss_state_e;
endpackage

// File: rtl/bss_period_timer.sv
module bss_period_timer #(
    parameter int PERIOD_CLKS  = 667,
    parameter int MAX_DUTY_PCT = 93,
    parameter int MIN_DUTY_PCT = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hi_active,
    output logic at_max,
    output logic min_met
);
    localparam int CNT_W    = $clog2(PERIOD_CLKS + 1);
    localparam int MAX_ON   = PERIOD_CLKS * MAX_DUTY_PCT / 100;
    localparam int MIN_ON   = PERIOD_CLKS * MIN_DUTY_PCT / 100;
    localparam int MAX_LAST = (MAX_ON > 0) ? MAX_ON - 1 : 0;
    localparam int MIN_LAST = (MIN_ON > 0) ? MIN_ON - 1 : 0;
    localparam logic [CNT_W-1:0] PER_SAT  = CNT_W'(PERIOD_CLKS);
    localparam logic [CNT_W-1:0] MAX_CMP  = CNT_W'(MAX_LAST);
    localparam logic [CNT_W-1:0] MIN_CMP  = CNT_W'(MIN_LAST);

    logic [CNT_W-1:0] per_cnt;   // clocks since the tick-sampling edge
    logic [CNT_W-1:0] hi_cnt;    // clocks spent in the high-side state

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_cnt <= '0;
        end else if (tick) begin
            per_cnt <= '0;
        end else if (per_cnt != PER_SAT) begin
            per_cnt <= per_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (!hi_active) begin
            hi_cnt <= '0;
        end else if (hi_cnt != PER_SAT) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assign at_max  = (per_cnt >= MAX_CMP);
    assign min_met = (hi_cnt >= MIN_CMP);

    AST_MAX_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        hi_active |-> (per_cnt <= MAX_CMP)); // R4
endmodule

// File: rtl/bss_deadtime.sv
module bss_deadtime #(
    parameter int BBM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BBM_W-1:0] bbm,
    output logic             done
);
    logic [BBM_W-1:0] dt_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dt_cnt <= '0;
        end else if (load) begin
            dt_cnt <= (bbm == '0) ? '0 : bbm - 1'b1;
        end else if (dt_cnt != '0) begin
            dt_cnt <= dt_cnt - 1'b1;
        end
    end

    assign done = (dt_cnt == '0);

    AST_DT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load && bbm > 1) |=> !done); // R1
endmodule

// File: rtl/bss_mode_track.sv
module bss_mode_track (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick_take,
    input  logic hi_enter,
    output logic skip_mode
);
    logic pulse_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_seen <= 1'b1;
            skip_mode  <= 1'b0;
        end else if (clr) begin
            pulse_seen <= 1'b1;
            skip_mode  <= 1'b0;
        end else if (tick_take) begin
            skip_mode  <= ~pulse_seen;
            pulse_seen <= 1'b0;
        end else if (hi_enter) begin
            pulse_seen <= 1'b1;
        end
    end

    AST_SKIP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !skip_mode); // R9
endmodule

// File: rtl/buck_switch_seq.sv
module buck_switch_seq
    import bss_pkg::*;
#(
    parameter int PERIOD_CLKS  = 667,
    parameter int MAX_DUTY_PCT = 93,
    parameter int MIN_DUTY_PCT = 7,
    parameter int BBM_W        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clamp,
    input  logic             tick,
    input  logic [BBM_W-1:0] bbm,
    input  logic             trip_on,
    input  logic             trip_ilim,
    input  logic             trip_light,
    input  logic             zero_cross,
    input  logic             out_above,
    output logic             gate_hi,
    output logic             gate_lo,
    output logic             skip_mode
);
    bss_state_e state, nxt;
    logic at_max, min_met, dt_done, dt_load;
    logic hi_enter, tick_take, pulse_end;

    bss_period_timer #(
        .PERIOD_CLKS (PERIOD_CLKS),
        .MAX_DUTY_PCT(MAX_DUTY_PCT),
        .MIN_DUTY_PCT(MIN_DUTY_PCT)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .hi_active(state == ST_HIGH),
        .at_max   (at_max),
        .min_met  (min_met)
    );

    bss_deadtime #(.BBM_W(BBM_W)) u_dt (
        .clk  (clk),
        .rst_n(rst_n),
        .load (dt_load),
        .bbm  (bbm),
        .done (dt_done)
    );

    bss_mode_track u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!en),
        .tick_take(tick_take),
        .hi_enter (hi_enter),
        .skip_mode(skip_mode)
    );

    // End of the high-side pulse: the limit and the clamp act at once,
    // the regulation flags only once the minimum on-time is met.
    assign pulse_end = clamp || trip_ilim || at_max ||
                       (min_met && (skip_mode ? trip_light : trip_on));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        if (!en) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:   nxt = clamp ? ST_CLAMP : ST_IDLE;
                ST_CLAMP: if (!clamp) nxt = ST_IDLE;
                ST_IDLE: begin
                    if (clamp)     nxt = ST_CLAMP;
                    else if (tick) nxt = out_above ? ST_IDLE : ST_DT_HI;
                end
                ST_DT_HI: begin
                    if (clamp)        nxt = ST_CLAMP;
                    else if (dt_done) nxt = ST_HIGH;
                end
                ST_HIGH: if (pulse_end) nxt = ST_DT_LO;
                ST_DT_LO: begin
                    if (clamp) begin
                        if (dt_done) nxt = ST_CLAMP;
                    end else if (tick) begin
                        nxt = out_above ? ST_IDLE : ST_DT_HI;
                    end else if (dt_done) begin
                        nxt = ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (clamp)           nxt = ST_CLAMP;
                    else if (tick)       nxt = out_above ? ST_IDLE : ST_DT_HI;
                    else if (zero_cross) nxt = ST_IDLE;
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    assign dt_load   = ((nxt == ST_DT_HI) && (state != ST_DT_HI)) ||
                       ((nxt == ST_DT_LO) && (state != ST_DT_LO));
    assign hi_enter  = (state == ST_DT_HI) && (nxt == ST_HIGH);
    assign tick_take = en && !clamp && tick &&
                       ((state == ST_IDLE) || (state == ST_DT_LO) || (state == ST_LOW));

    // Outputs
    always_comb begin
        gate_hi = (state == ST_HIGH) && !trip_ilim;
        gate_lo = (state == ST_LOW) || (state == ST_CLAMP);
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo)); // R1
    AST_GAP_HI_LO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gate_hi) |-> !gate_lo); // R1
    AST_GAP_LO_HI: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gate_lo) |-> !gate_hi); // R1
    AST_ILIM_END: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state == ST_HIGH && trip_ilim) |=> (state == ST_DT_LO || state == ST_OFF)); // R5
    AST_DIS_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!gate_hi && !gate_lo)); // R9
    AST_CLAMP_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (en && clamp) |=> !gate_hi); // R10
endmodule

// File: tb/sim_buck_switch_seq.sv
`timescale 1ns/1ps
module sim_buck_switch_seq;
    localparam int P = 100;
    localparam int NV = 15;
    localparam logic [7:0] NEV = 8'd255;

    typedef struct packed {
        logic [3:0] bbm;
        logic       above;
        logic [7:0] trip;
        logic [7:0] light;
        logic [7:0] ilim;
        logic [7:0] zc;
        logic       skip;
        logic [7:0] hr;
        logic [7:0] hf;
        logic [7:0] lr;
        logic [7:0] lf;
    } vec_t;

    // Flag offsets are clocks after the tick-sampling edge; 100 = no edge in period.
    localparam vec_t VECS [0:NV-1] = '{
        '{4'd5,  1'b0, 8'd30, NEV,   NEV,   NEV,   1'b0, 8'd5,   8'd31,  8'd36,  8'd100}, // R2
        '{4'd5,  1'b0, 8'd0,  NEV,   NEV,   NEV,   1'b0, 8'd5,   8'd12,  8'd17,  8'd100}, // R3
        '{4'd5,  1'b0, NEV,   NEV,   NEV,   NEV,   1'b0, 8'd5,   8'd93,  8'd98,  8'd100}, // R4
        '{4'd5,  1'b0, NEV,   NEV,   8'd20, NEV,   1'b0, 8'd5,   8'd21,  8'd26,  8'd100}, // R5
        '{4'd5,  1'b0, 8'd30, NEV,   NEV,   8'd50, 1'b0, 8'd5,   8'd31,  8'd36,  8'd51},  // R6
        '{4'd5,  1'b0, 8'd30, NEV,   NEV,   8'd10, 1'b0, 8'd5,   8'd31,  8'd36,  8'd37},  // R6
        '{4'd5,  1'b1, 8'd30, NEV,   NEV,   NEV,   1'b0, 8'd100, 8'd100, 8'd100, 8'd100}, // R7
        '{4'd5,  1'b0, 8'd10, 8'd40, NEV,   8'd60, 1'b1, 8'd5,   8'd41,  8'd46,  8'd61},  // R8
        '{4'd5,  1'b0, 8'd25, 8'd60, NEV,   NEV,   1'b0, 8'd5,   8'd26,  8'd31,  8'd100}, // R2
        '{4'd5,  1'b1, NEV,   NEV,   NEV,   NEV,   1'b0, 8'd100, 8'd100, 8'd100, 8'd100}, // R7
        '{4'd5,  1'b1, NEV,   NEV,   NEV,   NEV,   1'b1, 8'd100, 8'd100, 8'd100, 8'd100}, // R8
        '{4'd5,  1'b0, 8'd5,  NEV,   NEV,   NEV,   1'b1, 8'd5,   8'd93,  8'd98,  8'd100}, // R8
        '{4'd10, 1'b0, 8'd40, NEV,   NEV,   NEV,   1'b0, 8'd10,  8'd41,  8'd51,  8'd100}, // R1
        '{4'd0,  1'b0, 8'd30, NEV,   NEV,   NEV,   1'b0, 8'd1,   8'd31,  8'd32,  8'd100}, // R1
        '{4'd12, 1'b0, 8'd0,  NEV,   NEV,   NEV,   1'b0, 8'd12,  8'd19,  8'd31,  8'd100}  // R3
    };

    function automatic string vtag(input int i);
        case (i)
            0, 8:      return "R2";
            1, 14:     return "R3";
            2:         return "R4";
            3:         return "R5";
            4, 5:      return "R6";
            6, 9:      return "R7";
            7, 10, 11: return "R8";
            default:   return "R1";
        endcase
    endfunction

    logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, clamp = 1'b0, tick = 1'b0;
    logic [3:0] bbm = 4'd5;
    logic trip_on = 1'b0, trip_ilim = 1'b0, trip_light = 1'b0;
    logic zero_cross = 1'b0, out_above = 1'b0;
    logic gate_hi, gate_lo, skip_mode;
    int nchk = 0, nfail = 0;

    always #2.5 clk = ~clk;

    buck_switch_seq #(.PERIOD_CLKS(P), .BBM_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .clamp(clamp), .tick(tick), .bbm(bbm),
        .trip_on(trip_on), .trip_ilim(trip_ilim), .trip_light(trip_light),
        .zero_cross(zero_cross), .out_above(out_above),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .skip_mode(skip_mode)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        nchk++;
        if (got != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic run_vec(input int vi);
        vec_t v;
        logic hs [0:P-1];
        logic ls [0:P-1];
        int hr, hf, lr, lf, sk;
        v = VECS[vi];
        bbm = v.bbm; out_above = v.above; tick = 1'b1;
        trip_on = 0; trip_light = 0; trip_ilim = 0; zero_cross = 0;
        sk = 0;
        for (int k = 0; k < P; k++) begin
            @(negedge clk);
            hs[k] = gate_hi; ls[k] = gate_lo;
            if (k == 0) sk = int'(skip_mode);
            tick       = 1'b0;
            trip_on    = (k >= int'(v.trip));
            trip_light = (k >= int'(v.light));
            trip_ilim  = (k >= int'(v.ilim));
            zero_cross = (k >= int'(v.zc));
        end
        hr = P; hf = P; lr = P; lf = P;
        for (int k = 0; k < P; k++) if (hr == P && hs[k]) hr = k;
        for (int k = 0; k < P; k++) if (hf == P && k > hr && !hs[k]) hf = k;
        for (int k = 0; k < P; k++) if (lr == P && ls[k]) lr = k;
        for (int k = 0; k < P; k++) if (lf == P && k > lr && !ls[k]) lf = k;
        chk(vtag(vi), $sformatf("vec %0d skip_mode", vi), sk, int'(v.skip));
        chk("R1", $sformatf("vec %0d hi rise", vi), hr, int'(v.hr));
        chk(vtag(vi), $sformatf("vec %0d hi fall", vi), hf, int'(v.hf));
        chk("R1", $sformatf("vec %0d lo rise", vi), lr, int'(v.lr));
        chk(vtag(vi), $sformatf("vec %0d lo fall", vi), lf, int'(v.lf));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin : stim
        en = 1'b1; clamp = 1'b1;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "reset gate_hi", int'(gate_hi), 0);
        chk("R11", "reset gate_lo", int'(gate_lo), 0);
        chk("R11", "reset skip_mode", int'(skip_mode), 0);
        clamp = 1'b0; rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R5: limit removes the high-side command in the same cycle
        bbm = 4'd5; out_above = 0; trip_on = 0; trip_light = 0; trip_ilim = 0; zero_cross = 0;
        tick = 1'b1; @(negedge clk); tick = 1'b0;          // index 0
        repeat (7) @(negedge clk);                          // index 7
        chk("R5", "hi on before limit", int'(gate_hi), 1);
        trip_ilim = 1'b1; #1;
        chk("R5", "hi same cycle as limit", int'(gate_hi), 0);
        @(negedge clk);
        chk("R5", "lo in dead time after limit", int'(gate_lo), 0);
        trip_ilim = 1'b0;
        repeat (91) @(negedge clk);                         // index 99

        // R10: clamp during a live pulse
        tick = 1'b1; @(negedge clk); tick = 1'b0;           // index 0
        repeat (10) @(negedge clk);                         // index 10
        chk("R10", "hi on before clamp", int'(gate_hi), 1);
        clamp = 1'b1;
        @(negedge clk);                                     // index 11
        chk("R10", "hi off after clamp", int'(gate_hi), 0);
        repeat (4) @(negedge clk);                          // index 15
        chk("R10", "lo waits dead time", int'(gate_lo), 0);
        @(negedge clk);                                     // index 16
        chk("R10", "lo on after dead time", int'(gate_lo), 1);
        repeat (83) @(negedge clk);
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        repeat (20) @(negedge clk);
        chk("R10", "tick ignored lo", int'(gate_lo), 1);
        chk("R10", "tick ignored hi", int'(gate_hi), 0);
        clamp = 1'b0; @(negedge clk);
        chk("R10", "release lo off", int'(gate_lo), 0);
        chk("R10", "release hi off", int'(gate_hi), 0);
        clamp = 1'b1; @(negedge clk);
        chk("R10", "clamp from idle lo on", int'(gate_lo), 1);
        clamp = 1'b0; @(negedge clk);

        // R9: two skipped periods, then disable together with clamp
        out_above = 1'b1;
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        repeat (99) @(negedge clk);
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        chk("R8", "skip after idle period", int'(skip_mode), 1);
        en = 1'b0; clamp = 1'b1; @(negedge clk);
        chk("R9", "disabled hi", int'(gate_hi), 0);
        chk("R9", "disabled lo over clamp", int'(gate_lo), 0);
        chk("R9", "disabled skip cleared", int'(skip_mode), 0);
        en = 1'b1; clamp = 1'b0; out_above = 1'b0; @(negedge clk);

        // R11 / R9: re-enabled channel pulses in fixed-frequency mode, then disable mid-pulse
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        chk("R11", "first period after enable", int'(skip_mode), 0);
        repeat (7) @(negedge clk);
        chk("R9", "hi on before disable", int'(gate_hi), 1);
        en = 1'b0; @(negedge clk);
        chk("R9", "hi off after disable", int'(gate_hi), 0);
        chk("R9", "lo off after disable", int'(gate_lo), 0);
        en = 1'b1; @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule